// File: doc/BRIEF.md
# Retirement Fault Arbiter

This block sits at the retirement point of a processor that has a fast speculative core and a simple in-order checker. For each instruction, in program order, it takes the core's record (program counter, instruction word, both source operands, result or address, and the following program counter) and the record the checker recomputed. It then decides whether the instruction commits as the core produced it, or whether a fault has to be resolved first. When every field agrees, the core's result retires. When any field differs, the block asks for a replay of the checker's inputs and waits for that third execution.

The third execution settles who was wrong. If it agrees with the core, the checker suffered a transient upset: the core's value retires and no restart is needed. If it still disagrees, the core is at fault. In that case the checker's value retires, the core is restarted at the program counter following that instruction, and the block spends exactly one instruction in a recovery mode. In recovery mode the checker's result retires on its own and core records are ignored. Each fault class has a saturating counter that is visible on output ports.

The block's control state, which is the mode and the two counters, is kept in three copies and read through a majority vote. A copy that disagrees with the others is outvoted and overwritten at the next edge, and while the disagreement lasts it is reported on a scrub output.

Top module: `rfa_fault_arb`

## Requirements
- R1: While reset is asserted, and after it is released, mode_o is 2'b00 (check mode). commit_o, replay_o, restart_o, flt_chk_o, flt_core_o and scrub_o are 0, and both counters are 0.
- R2: In check mode, when core_vld and chk_vld are both high and all six field pairs are equal, the next cycle shows commit_o=1 for one cycle, with commit_res_o equal to the core result and commit_npc_o equal to the core next PC. The mode stays 2'b00.
- R3: In check mode, when both strobes are high and any single one of the six field pairs differs, the next cycle shows replay_o=1, commit_o=0 and mode_o=2'b01 (replay wait).
- R4: In check mode, a cycle with only one of core_vld and chk_vld high causes no commit, no replay and no mode change.
- R5: In replay wait, a chk_vld whose six fields equal the held core record leads, the next cycle, to commit_o=1 with the held core result and next PC, and flt_chk_o=1. The next cycle also shows cnt_chk_o one higher, restart_o=0 and mode_o=2'b00.
- R6: In replay wait, a chk_vld whose record differs from the held core record leads, the next cycle, to commit_o=1 with the checker's result and next PC, and restart_o=1 with restart_pc_o equal to the checker's next PC. The next cycle also shows flt_core_o=1, cnt_core_o one higher and mode_o=2'b10 (recovery).
- R7: In recovery, the first cycle with chk_vld commits the checker's result and next PC on the next cycle and returns mode_o to 2'b00. core_vld has no effect in recovery, whether it comes alone or together with chk_vld.
- R8: In replay wait, core_vld without chk_vld causes no commit and leaves mode_o at 2'b01.
- R9: Each fault counter is CW bits wide and holds at 2^CW-1 once it reaches that value.
- R10: If one of the three copies of the mode register holds a wrong value, mode_o still shows the majority value and scrub_o is 1 until the next clock edge rewrites all copies. A state transition taken in that cycle follows the voted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_vld | input | 1 | Core record valid |
| core_pc | input | AW | Core program counter |
| core_ins | input | IW | Core instruction word |
| core_opa | input | DW | Core first source operand |
| core_opb | input | DW | Core second source operand |
| core_res | input | DW | Core result or address |
| core_npc | input | AW | Core next program counter |
| chk_vld | input | 1 | Checker record valid |
| chk_pc | input | AW | Checker program counter |
| chk_ins | input | IW | Checker instruction word |
| chk_opa | input | DW | Checker first source operand |
| chk_opb | input | DW | Checker second source operand |
| chk_res | input | DW | Checker result or address |
| chk_npc | input | AW | Checker next program counter |
| commit_o | output | 1 | One-cycle retire pulse |
| commit_res_o | output | DW | Retired result |
| commit_npc_o | output | AW | Retired next program counter |
| replay_o | output | 1 | Request to replay the checker's inputs |
| restart_o | output | 1 | Core restart pulse |
| restart_pc_o | output | AW | Core restart address |
| flt_chk_o | output | 1 | Transient-in-checker verdict pulse |
| flt_core_o | output | 1 | Core fault verdict pulse |
| mode_o | output | 2 | 00 check, 01 replay wait, 10 recovery |
| cnt_chk_o | output | CW | Saturating transient-in-checker count |
| cnt_core_o | output | CW | Saturating core fault count |
| scrub_o | output | 1 | A triplicated copy disagrees this cycle |

## Verification
The case most likely to go wrong is a corrupted mode copy arriving in the same cycle as a mismatching instruction pair. A scrub event and a state transition then fall on the same edge. The bench provokes this by forcing one copy of the mode register to a wrong value at the moment it presents a differing pair. It then expects scrub_o high with mode_o still in check mode during that cycle, and after the edge a clean replay request with scrub_o low again. The counters are also driven to saturation while fault verdicts keep arriving, so that a saturating counter and a verdict pulse coincide.

// File: rtl/rfa_pkg.sv
package rfa_pkg;

   typedef enum logic [1:0] {
      MD_CHECK   = 2'b00,
      MD_REPLAY  = 2'b01,
      MD_RECOVER = 2'b10
   } mode_e;

   localparam int NFIELD = 6;

endpackage

// File: rtl/rfa_tmr_reg.sv
module rfa_tmr_reg #(
   parameter int           W      = 2,
   parameter logic [W-1:0] RST    = '0,
   parameter bit           TMR_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         mis
);
   localparam int NC = TMR_EN ? 3 : 1;

   logic [NC-1:0][W-1:0] cp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cp <= {NC{RST}};
      else        cp <= {NC{d}};
   end

   generate
      if (TMR_EN) begin : g_vote
         assign q   = (cp[0] & cp[1]) | (cp[0] & cp[2]) | (cp[1] & cp[2]);
         assign mis = (cp[0] != cp[1]) || (cp[0] != cp[2]);
      end else begin : g_single
         assign q   = cp[0];
         assign mis = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rfa_cmp.sv
module rfa_cmp #(
   parameter int AW = 32,
   parameter int IW = 32,
   parameter int DW = 32
) (
   input  logic [AW-1:0] a_pc,
   input  logic [IW-1:0] a_ins,
   input  logic [DW-1:0] a_opa,
   input  logic [DW-1:0] a_opb,
   input  logic [DW-1:0] a_res,
   input  logic [AW-1:0] a_npc,
   input  logic [AW-1:0] b_pc,
   input  logic [IW-1:0] b_ins,
   input  logic [DW-1:0] b_opa,
   input  logic [DW-1:0] b_opb,
   input  logic [DW-1:0] b_res,
   input  logic [AW-1:0] b_npc,
   output logic          same
);
   import rfa_pkg::*;

   logic [NFIELD-1:0] diff;

   always_comb begin
      diff[0] = (a_pc  != b_pc);
      diff[1] = (a_ins != b_ins);
      diff[2] = (a_opa != b_opa);
      diff[3] = (a_opb != b_opb);
      diff[4] = (a_res != b_res);
      diff[5] = (a_npc != b_npc);
   end

   assign same = ~|diff;
endmodule

// File: rtl/rfa_fault_arb.sv
module rfa_fault_arb
   import rfa_pkg::*;
#(
   parameter int AW     = 32,
   parameter int IW     = 32,
   parameter int DW     = 32,
   parameter int CW     = 4,
   parameter bit TMR_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          core_vld,
   input  logic [AW-1:0] core_pc,
   input  logic [IW-1:0] core_ins,
   input  logic [DW-1:0] core_opa,
   input  logic [DW-1:0] core_opb,
   input  logic [DW-1:0] core_res,
   input  logic [AW-1:0] core_npc,
   input  logic          chk_vld,
   input  logic [AW-1:0] chk_pc,
   input  logic [IW-1:0] chk_ins,
   input  logic [DW-1:0] chk_opa,
   input  logic [DW-1:0] chk_opb,
   input  logic [DW-1:0] chk_res,
   input  logic [AW-1:0] chk_npc,
   output logic          commit_o,
   output logic [DW-1:0] commit_res_o,
   output logic [AW-1:0] commit_npc_o,
   output logic          replay_o,
   output logic          restart_o,
   output logic [AW-1:0] restart_pc_o,
   output logic          flt_chk_o,
   output logic          flt_core_o,
   output logic [1:0]    mode_o,
   output logic [CW-1:0] cnt_chk_o,
   output logic [CW-1:0] cnt_core_o,
   output logic          scrub_o
);
   localparam logic [CW-1:0] CNT_TOP = '1;

   generate
      if (AW < 1 || IW < 1 || DW < 1) begin : g_bad_width
         $error("rfa_fault_arb: field widths must be positive");
      end
      if (CW < 1 || CW > 32) begin : g_bad_cw
         $error("rfa_fault_arb: CW out of range");
      end
   endgenerate

   // voted control state
   logic [1:0]    st_q, st_d;
   logic [CW-1:0] ck_q, ck_d, cc_q, cc_d;
   logic          mis_st, mis_ck, mis_cc;
   mode_e         st;

   rfa_tmr_reg #(.W(2), .RST(MD_CHECK), .TMR_EN(TMR_EN)) u_tmr_st (
      .clk(clk), .rst_n(rst_n), .d(st_d), .q(st_q), .mis(mis_st));
   rfa_tmr_reg #(.W(CW), .RST('0), .TMR_EN(TMR_EN)) u_tmr_ck (
      .clk(clk), .rst_n(rst_n), .d(ck_d), .q(ck_q), .mis(mis_ck));
   rfa_tmr_reg #(.W(CW), .RST('0), .TMR_EN(TMR_EN)) u_tmr_cc (
      .clk(clk), .rst_n(rst_n), .d(cc_d), .q(cc_q), .mis(mis_cc));

   assign st = mode_e'(st_q);

   // held core record for the third-opinion comparison
   logic [AW-1:0] h_pc, h_npc;
   logic [IW-1:0] h_ins;
   logic [DW-1:0] h_opa, h_opb, h_res;
   logic          hold_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_pc <= '0; h_ins <= '0; h_opa <= '0;
         h_opb <= '0; h_res <= '0; h_npc <= '0;
      end else if (hold_en) begin
         h_pc <= core_pc; h_ins <= core_ins; h_opa <= core_opa;
         h_opb <= core_opb; h_res <= core_res; h_npc <= core_npc;
      end
   end

   logic live_same, rep_same;

   rfa_cmp #(.AW(AW), .IW(IW), .DW(DW)) u_cmp_live (
      .a_pc(core_pc), .a_ins(core_ins), .a_opa(core_opa), .a_opb(core_opb),
      .a_res(core_res), .a_npc(core_npc),
      .b_pc(chk_pc), .b_ins(chk_ins), .b_opa(chk_opa), .b_opb(chk_opb),
      .b_res(chk_res), .b_npc(chk_npc), .same(live_same));

   rfa_cmp #(.AW(AW), .IW(IW), .DW(DW)) u_cmp_rep (
      .a_pc(h_pc), .a_ins(h_ins), .a_opa(h_opa), .a_opb(h_opb),
      .a_res(h_res), .a_npc(h_npc),
      .b_pc(chk_pc), .b_ins(chk_ins), .b_opa(chk_opa), .b_opb(chk_opb),
      .b_res(chk_res), .b_npc(chk_npc), .same(rep_same));

   // decision logic
   logic          n_commit, n_replay, n_restart, n_fck, n_fcc;
   logic [DW-1:0] n_res;
   logic [AW-1:0] n_npc, n_rpc;

   always_comb begin
      st_d      = st_q;
      ck_d      = ck_q;
      cc_d      = cc_q;
      hold_en   = 1'b0;
      n_commit  = 1'b0;
      n_replay  = 1'b0;
      n_restart = 1'b0;
      n_fck     = 1'b0;
      n_fcc     = 1'b0;
      n_res     = commit_res_o;
      n_npc     = commit_npc_o;
      n_rpc     = restart_pc_o;
      case (st)
         MD_CHECK: begin
            if (core_vld && chk_vld) begin
               if (live_same) begin
                  n_commit = 1'b1;
                  n_res    = core_res;
                  n_npc    = core_npc;
               end else begin
                  n_replay = 1'b1;
                  hold_en  = 1'b1;
                  st_d     = MD_REPLAY;
               end
            end
         end
         MD_REPLAY: begin
            if (chk_vld) begin
               n_commit = 1'b1;
               if (rep_same) begin
                  n_res = h_res;
                  n_npc = h_npc;
                  n_fck = 1'b1;
                  ck_d  = (ck_q == CNT_TOP) ? ck_q : ck_q + 1'b1;
                  st_d  = MD_CHECK;
               end else begin
                  n_res     = chk_res;
                  n_npc     = chk_npc;
                  n_restart = 1'b1;
                  n_rpc     = chk_npc;
                  n_fcc     = 1'b1;
                  cc_d      = (cc_q == CNT_TOP) ? cc_q : cc_q + 1'b1;
                  st_d      = MD_RECOVER;
               end
            end
         end
         MD_RECOVER: begin
            if (chk_vld) begin
               n_commit = 1'b1;
               n_res    = chk_res;
               n_npc    = chk_npc;
               st_d     = MD_CHECK;
            end
         end
         default: st_d = MD_CHECK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_o     <= 1'b0;
         replay_o     <= 1'b0;
         restart_o    <= 1'b0;
         flt_chk_o    <= 1'b0;
         flt_core_o   <= 1'b0;
         commit_res_o <= '0;
         commit_npc_o <= '0;
         restart_pc_o <= '0;
      end else begin
         commit_o     <= n_commit;
         replay_o     <= n_replay;
         restart_o    <= n_restart;
         flt_chk_o    <= n_fck;
         flt_core_o   <= n_fcc;
         commit_res_o <= n_res;
         commit_npc_o <= n_npc;
         restart_pc_o <= n_rpc;
      end
   end

   assign mode_o     = st_q;
   assign cnt_chk_o  = ck_q;
   assign cnt_core_o = cc_q;
   assign scrub_o    = mis_st | mis_ck | mis_cc;
endmodule

// File: rtl/rfa_fault_arb_chk.sv
module rfa_fault_arb_chk #(
   parameter int AW     = 32,
   parameter int IW     = 32,
   parameter int DW     = 32,
   parameter int CW     = 4,
   parameter bit TMR_EN = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          core_vld,
   input logic [AW-1:0] core_pc,
   input logic [IW-1:0] core_ins,
   input logic [DW-1:0] core_opa,
   input logic [DW-1:0] core_opb,
   input logic [DW-1:0] core_res,
   input logic [AW-1:0] core_npc,
   input logic          chk_vld,
   input logic [AW-1:0] chk_pc,
   input logic [IW-1:0] chk_ins,
   input logic [DW-1:0] chk_opa,
   input logic [DW-1:0] chk_opb,
   input logic [DW-1:0] chk_res,
   input logic [AW-1:0] chk_npc,
   input logic          commit_o,
   input logic          replay_o,
   input logic          restart_o,
   input logic          flt_chk_o,
   input logic          flt_core_o,
   input logic [1:0]    mode_o,
   input logic [CW-1:0] cnt_chk_o,
   input logic [CW-1:0] cnt_core_o
);
   logic pair_eq;
   assign pair_eq = (core_pc == chk_pc) && (core_ins == chk_ins) &&
                    (core_opa == chk_opa) && (core_opb == chk_opb) &&
                    (core_res == chk_res) && (core_npc == chk_npc);

   AST_MATCH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b00 && core_vld && chk_vld && pair_eq) |=> (commit_o && !replay_o && mode_o == 2'b00)); // R2

   AST_MISMATCH_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b00 && core_vld && chk_vld && !pair_eq) |=> (replay_o && !commit_o && mode_o == 2'b01)); // R3

   AST_SINGLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b00 && !(core_vld && chk_vld)) |=> (!commit_o && !replay_o && mode_o == 2'b00)); // R4

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      !(flt_chk_o && flt_core_o)); // R5

   AST_RESTART_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |-> (flt_core_o && commit_o && mode_o == 2'b10)); // R6

   AST_RECOVER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b10 && chk_vld) |=> (mode_o == 2'b00 && commit_o)); // R7

   AST_REPLAY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b01 && !chk_vld) |=> (mode_o == 2'b01 && !commit_o)); // R8

   AST_CORE_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt_core_o) |=> (&cnt_core_o)); // R9

   AST_CHK_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt_chk_o) |=> (&cnt_chk_o)); // R9
endmodule

bind rfa_fault_arb rfa_fault_arb_chk #(
   .AW(AW), .IW(IW), .DW(DW), .CW(CW), .TMR_EN(TMR_EN)
) u_rfa_fault_arb_chk (.*);

// File: tb/rfa_fault_arb_bench.sv
`timescale 1ns/1ps
module rfa_fault_arb_bench;
   localparam int AW = 32, IW = 32, DW = 32, CW = 4;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          core_vld = 1'b0, chk_vld = 1'b0;
   logic [AW-1:0] core_pc = '0, core_npc = '0, chk_pc = '0, chk_npc = '0;
   logic [IW-1:0] core_ins = '0, chk_ins = '0;
   logic [DW-1:0] core_opa = '0, core_opb = '0, core_res = '0;
   logic [DW-1:0] chk_opa = '0, chk_opb = '0, chk_res = '0;
   logic          commit_o, replay_o, restart_o, flt_chk_o, flt_core_o, scrub_o;
   logic [DW-1:0] commit_res_o;
   logic [AW-1:0] commit_npc_o, restart_pc_o;
   logic [1:0]    mode_o;
   logic [CW-1:0] cnt_chk_o, cnt_core_o;

   rfa_fault_arb #(.AW(AW), .IW(IW), .DW(DW), .CW(CW)) u_rfa_fault_arb (.*);

   int    total = 0, bad = 0;
   string cur_tag = "R1";
   bit    done = 1'b0;

   task automatic check(string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", cur_tag, what, act, exp);
      end
   endtask

   // staged records
   logic [31:0] s_c [6];
   logic [31:0] s_k [6];

   task automatic rnd();
      for (int i = 0; i < 6; i++) s_c[i] = $urandom;
      for (int i = 0; i < 6; i++) s_k[i] = s_c[i];
   endtask

   task automatic rnd_k();
      for (int i = 0; i < 6; i++) s_k[i] = $urandom;
   endtask

   task automatic drive(bit cv, bit kv);
      @(posedge clk); #2;
      core_vld = cv; chk_vld = kv;
      core_pc = s_c[0]; core_ins = s_c[1]; core_opa = s_c[2];
      core_opb = s_c[3]; core_res = s_c[4]; core_npc = s_c[5];
      chk_pc = s_k[0]; chk_ins = s_k[1]; chk_opa = s_k[2];
      chk_opb = s_k[3]; chk_res = s_k[4]; chk_npc = s_k[5];
   endtask

   // reference model
   int          m_st;
   int          m_ck, m_cc;
   bit          e_commit, e_replay, e_restart, e_fk, e_fc, e_scrub;
   logic [31:0] e_res, e_npc, e_rpc;
   logic [31:0] m_h [6];

   function automatic bit rec_eq_live();
      return core_pc == chk_pc && core_ins == chk_ins && core_opa == chk_opa &&
             core_opb == chk_opb && core_res == chk_res && core_npc == chk_npc;
   endfunction

   function automatic bit rec_eq_held();
      return m_h[0] == chk_pc && m_h[1] == chk_ins && m_h[2] == chk_opa &&
             m_h[3] == chk_opb && m_h[4] == chk_res && m_h[5] == chk_npc;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_ck = 0; m_cc = 0;
         e_commit = 0; e_replay = 0; e_restart = 0; e_fk = 0; e_fc = 0; e_scrub = 0;
         e_res = 0; e_npc = 0; e_rpc = 0;
      end else begin
         e_commit = 0; e_replay = 0; e_restart = 0; e_fk = 0; e_fc = 0; e_scrub = 0;
         if (m_st == 0) begin
            if (core_vld && chk_vld) begin
               if (rec_eq_live()) begin
                  e_commit = 1; e_res = core_res; e_npc = core_npc;
               end else begin
                  e_replay = 1; m_st = 1;
                  m_h[0] = core_pc; m_h[1] = core_ins; m_h[2] = core_opa;
                  m_h[3] = core_opb; m_h[4] = core_res; m_h[5] = core_npc;
               end
            end
         end else if (m_st == 1) begin
            if (chk_vld) begin
               e_commit = 1;
               if (rec_eq_held()) begin
                  e_res = m_h[4]; e_npc = m_h[5]; e_fk = 1;
                  if (m_ck < CMAX) m_ck++;
                  m_st = 0;
               end else begin
                  e_res = chk_res; e_npc = chk_npc; e_restart = 1; e_rpc = chk_npc;
                  e_fc = 1;
                  if (m_cc < CMAX) m_cc++;
                  m_st = 2;
               end
            end
         end else begin
            if (chk_vld) begin
               e_commit = 1; e_res = chk_res; e_npc = chk_npc; m_st = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("mode_o", 32'(mode_o), 32'(m_st));
         check("commit_o", 32'(commit_o), 32'(e_commit));
         check("replay_o", 32'(replay_o), 32'(e_replay));
         check("restart_o", 32'(restart_o), 32'(e_restart));
         check("flt_chk_o", 32'(flt_chk_o), 32'(e_fk));
         check("flt_core_o", 32'(flt_core_o), 32'(e_fc));
         check("cnt_chk_o", 32'(cnt_chk_o), 32'(m_ck));
         check("cnt_core_o", 32'(cnt_core_o), 32'(m_cc));
         check("scrub_o", 32'(scrub_o), 32'(e_scrub));
         if (e_commit) begin
            check("commit_res_o", commit_res_o, e_res);
            check("commit_npc_o", commit_npc_o, e_npc);
         end
         if (e_restart) check("restart_pc_o", restart_pc_o, e_rpc);
      end
   end

   // one mode copy corrupted until the following falling edge
   task automatic corrupt();
      logic [1:0] v;
      v = 2'(m_st);
      force u_rfa_fault_arb.u_tmr_st.cp = {v, v ^ 2'b11, v};
      e_scrub = 1;
      @(negedge clk); #1;
      release u_rfa_fault_arb.u_tmr_st.cp;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 6; i++) begin s_c[i] = 0; s_k[i] = 0; end
      repeat (3) @(posedge clk);
      #5;
      cur_tag = "R1";
      check("mode_o", 32'(mode_o), 0);
      check("commit_o", 32'(commit_o), 0);
      check("replay_o", 32'(replay_o), 0);
      check("restart_o", 32'(restart_o), 0);
      check("flt_chk_o", 32'(flt_chk_o), 0);
      check("flt_core_o", 32'(flt_core_o), 0);
      check("cnt_chk_o", 32'(cnt_chk_o), 0);
      check("cnt_core_o", 32'(cnt_core_o), 0);
      check("scrub_o", 32'(scrub_o), 0);
      @(posedge clk); #2; rst_n = 1'b1;

      cur_tag = "R2";
      for (int n = 0; n < 8; n++) begin rnd(); drive(1, 1); end
      drive(0, 0);

      cur_tag = "R4";
      rnd(); drive(1, 0); drive(0, 1);
      s_k[4] = ~s_c[4]; drive(1, 0); drive(0, 1); drive(0, 0);

      for (int f = 0; f < 6; f++) begin
         cur_tag = "R3";
         rnd(); s_k[f] = s_k[f] ^ 32'h1; drive(1, 1);
         cur_tag = "R8";
         drive(1, 0); drive(0, 0);
         cur_tag = "R5";
         for (int i = 0; i < 6; i++) s_k[i] = s_c[i];
         drive(0, 1); drive(0, 0);
      end

      for (int n = 0; n < 3; n++) begin
         cur_tag = "R6";
         rnd(); s_k[4] = ~s_c[4]; drive(1, 1);
         rnd_k(); drive(0, 1);
         cur_tag = "R7";
         rnd(); drive(1, 0); drive(0, 0);
         rnd_k(); drive(1, 1); drive(0, 0);
         rnd(); drive(1, 1); drive(0, 0);
      end

      cur_tag = "R9";
      for (int n = 0; n < CMAX + 3; n++) begin
         rnd(); s_k[0] = ~s_c[0]; drive(1, 1);
         rnd_k(); drive(0, 1); drive(0, 1);
      end
      for (int n = 0; n < CMAX + 3; n++) begin
         rnd(); s_k[2] = ~s_c[2]; drive(1, 1);
         for (int i = 0; i < 6; i++) s_k[i] = s_c[i];
         drive(0, 1);
      end
      drive(0, 0);

      cur_tag = "R10";
      drive(0, 0); corrupt();
      drive(0, 0);
      rnd(); s_k[5] = ~s_c[5]; drive(1, 1); corrupt();
      drive(0, 0); corrupt();
      for (int i = 0; i < 6; i++) s_k[i] = s_c[i];
      drive(0, 1); drive(0, 0);
      rnd(); drive(1, 1); corrupt();
      drive(0, 0); drive(0, 0);
      @(negedge clk); #1;
      finish_run();
   end
endmodule